// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on a byte-wide receive path just after frame delineation. It reads the destination address of each frame and decides whether the frame goes on or is discarded. The destination address is the first six bytes of the frame. A frame is accepted when its address matches any of the following:

- the programmed primary station address;
- one of up to four extra station addresses, each with its own enable;
- the all-ones broadcast address;
- the reserved flow-control address `01-80-C2-00-00-01`;
- any group address, when group acceptance is switched on.

Filtering is active only while at least one filter control is set. With every control cleared, the block is promiscuous and lets every complete frame through.

The decision is known only after the sixth byte arrives. Until then, the bytes of the current frame wait in a six-entry holding queue, so no byte of a rejected frame ever reaches the output. Accepted bytes leave the queue one per cycle, in order, with their start and end markers unchanged. Each rejected frame, including a frame too short to carry a full address, produces a one-cycle drop strobe and advances a saturating drop counter. Configuration must stay stable while a frame's address is arriving.

Top module: `da_filter`

## Requirements
- R1: The destination address is the first six bytes of a frame (the byte with `in_sof` is byte 1). Byte 1 lines up with bits 47:40 of every 48-bit address input, and byte 6 with bits 7:0. When `cfg_uc_check`, `cfg_mc_accept` and every effective extra-address enable are all 0, every frame of six or more bytes passes unchanged.
- R2: While filtering is active, a frame whose address equals `cfg_primary` is passed. A frame whose address matches no accept condition is dropped.
- R3: Extra address i sits at `cfg_supp_addr[48*i+47:48*i]`. It is compared only when i < `NUM_SUPP` and `cfg_supp_en[i]` is 1.
- R4: A group address (bit 40 of the address, i.e. bit 0 of byte 1, is 1) that is neither broadcast nor the flow-control address is passed only when `cfg_mc_accept` is 1.
- R5: The address FF-FF-FF-FF-FF-FF is always passed.
- R6: The address 01-80-C2-00-00-01 is always passed.
- R7: No byte of a dropped frame appears on the output. Accepted frames appear byte for byte, in order, with `out_sof` on the first byte and `out_eof` on the last. The output markers are 0 whenever `out_valid` is 0.
- R8: A frame whose `in_eof` comes on byte 1 to 5 is dropped, and `runt_flag` pulses together with `drop_pulse`.
- R9: `drop_pulse` is high for exactly one cycle, in the cycle after the `in_eof` byte of each dropped frame. In that same cycle, `drop_count` has risen by one, holding at 2^`CNT_W`-1 once it gets there.
- R10: A valid byte outside a frame (no `in_sof`, and no open frame) is ignored. It is neither output nor counted.
- R11: Frames with no idle cycle between them, and frames with idle gaps between bytes, are filtered correctly without losing bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| cfg_primary | input | 48 | Primary station address |
| cfg_supp_addr | input | 192 | Four extra station addresses, 48 bits each |
| cfg_supp_en | input | 4 | Per-slot enables for the extra addresses |
| cfg_uc_check | input | 1 | Enables station address filtering |
| cfg_mc_accept | input | 1 | Accepts group addresses; also enables filtering |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of passed frame |
| out_eof | output | 1 | Last byte of passed frame |
| drop_pulse | output | 1 | One-cycle strobe per dropped frame |
| runt_flag | output | 1 | Set with `drop_pulse` when the frame was short |
| drop_count | output | CNT_W | Saturating count of dropped frames |

## Verification
The bound checker watches every cycle for the following:

- **Output framing:** no orphan output byte, and no marker without valid.
- **Holding queue:** occupancy never goes above six.
- **Drop strobe:** it always follows an input end byte, and a runt strobe never appears without a drop.
- **Counter:** it steps by one per drop, holds between drops, and stays put at saturation.

The accept decision itself can only be shown by the scenarios. Each one compares the bytes that emerge against the frames it sent. The cases covered are:

- the primary address, including an address with two bytes swapped;
- enabled, disabled and absent extra slots;
- group addresses with acceptance off and on;
- the two reserved addresses, runts, back-to-back frames and stray bytes.

// File: rtl/da_filter.sv
module da_filter #(
  parameter int NUM_SUPP = 4,
  parameter int CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [47:0]      cfg_primary,
  input  logic [191:0]     cfg_supp_addr,
  input  logic [3:0]       cfg_supp_en,
  input  logic             cfg_uc_check,
  input  logic             cfg_mc_accept,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             drop_pulse,
  output logic             runt_flag,
  output logic [CNT_W-1:0] drop_count
);
  localparam int DEPTH = 6;
  localparam int QW = $clog2(DEPTH + 1);
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] PAUSE = 48'h0180_C200_0001;
  localparam logic [3:0] SUPP_MASK = 4'((5'd1 << NUM_SUPP) - 5'd1);

  logic [2:0]  idx;
  logic [39:0] da_hi;
  logic        frame_keep;

  logic [7:0]  q_data [DEPTH];
  logic        q_sof  [DEPTH];
  logic        q_eof  [DEPTH];
  logic        q_dec  [DEPTH];
  logic        q_keep [DEPTH];
  logic [QW-1:0] cnt;

  logic [7:0]  n_data [DEPTH];
  logic        n_sof  [DEPTH];
  logic        n_eof  [DEPTH];
  logic        n_dec  [DEPTH];
  logic        n_keep [DEPTH];
  logic [QW-1:0] n_cnt;

  wire         in_byte = in_valid && (in_sof || idx != 3'd0);
  wire [2:0]   pos     = in_sof ? 3'd1 : (idx == 3'd7 ? 3'd7 : idx + 3'd1);
  wire [47:0]  da      = {da_hi, in_data};

  logic [3:0] supp_eq;
  for (genvar i = 0; i < 4; i++) begin : g_supp
    assign supp_eq[i] = cfg_supp_addr[48*i +: 48] == da;
  end

  wire [3:0] supp_on  = cfg_supp_en & SUPP_MASK;
  wire       filt_on  = cfg_uc_check | cfg_mc_accept | (|supp_on);
  wire       accept   = !filt_on || da == cfg_primary || |(supp_on & supp_eq) ||
                        da == BCAST || da == PAUSE || (da[40] && cfg_mc_accept);

  wire       is_runt   = in_byte && in_eof && pos < 3'd6;
  wire       decide    = in_byte && (pos == 3'd6 || is_runt);
  wire       keep_now  = pos == 3'd6 && accept;
  wire       byte_dec  = pos >= 3'd6 || in_eof;
  wire       byte_keep = pos == 3'd7 ? frame_keep : keep_now;
  wire       drop_end  = in_byte && in_eof && !byte_keep;
  wire       pop       = cnt != '0 && q_dec[0];

  always_comb begin
    logic [QW-1:0] wp;
    for (int i = 0; i < DEPTH; i++) begin
      n_data[i] = q_data[i];
      n_sof[i]  = q_sof[i];
      n_eof[i]  = q_eof[i];
      n_dec[i]  = q_dec[i];
      n_keep[i] = q_keep[i];
    end
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        n_data[i] = q_data[i+1];
        n_sof[i]  = q_sof[i+1];
        n_eof[i]  = q_eof[i+1];
        n_dec[i]  = q_dec[i+1];
        n_keep[i] = q_keep[i+1];
      end
      n_dec[DEPTH-1] = 1'b0;
    end
    wp = cnt - QW'(pop);
    if (decide) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (QW'(i) < wp && !n_dec[i]) begin
          n_dec[i]  = 1'b1;
          n_keep[i] = keep_now;
        end
      end
    end
    n_cnt = wp;
    if (in_byte && wp < QW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (QW'(i) == wp) begin
          n_data[i] = in_data;
          n_sof[i]  = in_sof;
          n_eof[i]  = in_eof;
          n_dec[i]  = byte_dec;
          n_keep[i] = byte_keep;
        end
      end
      n_cnt = wp + QW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx        <= '0;
      da_hi      <= '0;
      frame_keep <= 1'b0;
      cnt        <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sof    <= 1'b0;
      out_eof    <= 1'b0;
      drop_pulse <= 1'b0;
      runt_flag  <= 1'b0;
      drop_count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_data[i] <= '0;
        q_sof[i]  <= 1'b0;
        q_eof[i]  <= 1'b0;
        q_dec[i]  <= 1'b0;
        q_keep[i] <= 1'b0;
      end
    end else begin
      if (in_byte) begin
        idx <= in_eof ? 3'd0 : pos;
        if (pos <= 3'd5) da_hi <= {da_hi[31:0], in_data};
        if (pos == 3'd6) frame_keep <= accept;
      end
      cnt <= n_cnt;
      for (int i = 0; i < DEPTH; i++) begin
        q_data[i] <= n_data[i];
        q_sof[i]  <= n_sof[i];
        q_eof[i]  <= n_eof[i];
        q_dec[i]  <= n_dec[i];
        q_keep[i] <= n_keep[i];
      end
      out_valid  <= pop && q_keep[0];
      out_data   <= q_data[0];
      out_sof    <= pop && q_keep[0] && q_sof[0];
      out_eof    <= pop && q_keep[0] && q_eof[0];
      drop_pulse <= drop_end;
      runt_flag  <= is_runt;
      if (drop_end && drop_count != '1) drop_count <= drop_count + 1'b1;
    end
  end
endmodule

// File: rtl/da_filter_chk.sv
module da_filter_chk #(
  parameter int CNT_W = 32,
  parameter int QW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_eof,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eof,
  input logic             drop_pulse,
  input logic             runt_flag,
  input logic [CNT_W-1:0] drop_count,
  input logic [QW-1:0]    q_cnt
);
  logic open;
  always_ff @(posedge clk) begin
    if (!rst_n) open <= 1'b0;
    else if (out_valid) open <= !out_eof;
  end

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_sof && !out_eof);
  p_no_orphan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sof |-> open);
  p_no_nested_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> !open);
  p_runt_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    runt_flag |-> drop_pulse);
  p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> $past(in_valid && in_eof));
  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !drop_pulse |-> $stable(drop_count));
  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse && $past(drop_count) != '1 |-> drop_count == $past(drop_count) + 1'b1);
  p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse && $past(drop_count) == '1 |-> drop_count == '1);
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QW'(6));
endmodule

bind da_filter da_filter_chk #(.CNT_W(CNT_W), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
  .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
  .drop_pulse(drop_pulse), .runt_flag(runt_flag), .drop_count(drop_count),
  .q_cnt(cnt)
);

// File: tb/tb_da_filter.sv
`timescale 1ns/1ps
module tb_da_filter;
  localparam int CW = 3;
  localparam logic [47:0] PRIM = 48'h0211_2233_4455;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = '0;
  logic [47:0] cfg_primary = PRIM;
  logic [191:0] cfg_supp_addr = '0;
  logic [3:0] cfg_supp_en = '0;
  logic cfg_uc_check = 0, cfg_mc_accept = 0;
  logic out_valid, out_sof, out_eof, drop_pulse, runt_flag;
  logic [7:0] out_data;
  logic [CW-1:0] drop_count;

  int checks = 0, fails = 0, n_drop = 0, n_runt = 0, exp_cnt = 0;
  logic [9:0] got_q[$];
  logic [9:0] exp_q[$];

  always #2.5 clk = ~clk;

  da_filter #(.NUM_SUPP(3), .CNT_W(CW)) dut (.*);

  always @(negedge clk) begin
    if (out_valid) got_q.push_back({out_sof, out_eof, out_data});
    if (drop_pulse) n_drop++;
    if (runt_flag) n_runt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0;
    end
  endtask

  task automatic send(input logic [47:0] da, input int len, input int gap, input bit pass);
    for (int i = 0; i < len; i++) begin
      if (i > 0) idle(gap);
      @(negedge clk);
      in_valid = 1;
      in_sof = (i == 0);
      in_eof = (i == len - 1);
      in_data = (i < 6) ? da[47 - 8*i -: 8] : 8'(8'h30 + i);
      if (pass) exp_q.push_back({in_sof, in_eof, in_data});
    end
    if (!pass) exp_cnt = (exp_cnt == 7) ? 7 : exp_cnt + 1;
  endtask

  task automatic settle(input string req, input int drops_before, input int drops_exp);
    idle(14);
    check(got_q.size() == exp_q.size(), {req, " byte count"}, got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      for (int i = 0; i < got_q.size(); i++)
        check(got_q[i] == exp_q[i], {req, " byte"}, got_q[i], exp_q[i]);
    check(n_drop - drops_before == drops_exp, {req, " drop strobes"}, n_drop - drops_before, drops_exp);
    check(int'(drop_count) == exp_cnt, {req, " drop_count R9"}, drop_count, exp_cnt);
    got_q.delete(); exp_q.delete();
  endtask

  task automatic t_reset;
    check(!out_valid && !drop_pulse && !runt_flag && drop_count == 0, "R7 reset state", out_valid, 0);
  endtask

  task automatic t_promisc;
    int d = n_drop;
    cfg_uc_check = 0; cfg_mc_accept = 0; cfg_supp_en = 0;
    send(48'h0A12_3456_789A, 10, 0, 1);
    send(48'h0100_5E00_0010, 8, 0, 1);
    settle("R1 promiscuous", d, 0);
  endtask

  task automatic t_primary;
    int d = n_drop;
    cfg_uc_check = 1;
    send(PRIM, 9, 0, 1);
    send(48'h0211_2233_5544, 9, 0, 0);
    settle("R2 primary / R1 byte order", d, 1);
  endtask

  task automatic t_supp;
    int d = n_drop;
    cfg_supp_addr[0 +: 48]   = 48'h02AA_0000_0001;
    cfg_supp_addr[48 +: 48]  = 48'h02AA_0000_0002;
    cfg_supp_addr[96 +: 48]  = 48'h02AA_0000_0003;
    cfg_supp_addr[144 +: 48] = 48'h02AA_0000_0004;
    cfg_supp_en = 4'b1101;
    send(48'h02AA_0000_0001, 8, 0, 1);
    send(48'h02AA_0000_0002, 8, 0, 0);
    send(48'h02AA_0000_0003, 8, 0, 1);
    send(48'h02AA_0000_0004, 8, 0, 0);
    settle("R3 extra addresses", d, 2);
    cfg_supp_en = 0;
  endtask

  task automatic t_mcast;
    int d = n_drop;
    cfg_mc_accept = 0;
    send(48'h0100_5E00_0010, 8, 0, 0);
    settle("R4 group rejected", d, 1);
    d = n_drop;
    cfg_mc_accept = 1;
    send(48'h0100_5E00_0010, 8, 0, 1);
    settle("R4 group accepted", d, 0);
    cfg_mc_accept = 0;
  endtask

  task automatic t_reserved;
    int d = n_drop;
    send(48'hFFFF_FFFF_FFFF, 7, 0, 1);
    settle("R5 broadcast", d, 0);
    d = n_drop;
    send(48'h0180_C200_0001, 7, 0, 1);
    settle("R6 flow-control address", d, 0);
  endtask

  task automatic t_runt;
    int d = n_drop, r = n_runt;
    send(PRIM, 4, 0, 0);
    settle("R8 runt", d, 1);
    check(n_runt - r == 1, "R8 runt flag", n_runt - r, 1);
    d = n_drop; r = n_runt;
    send(PRIM, 6, 0, 1);
    settle("R8 six-byte frame", d, 0);
    check(n_runt == r, "R8 no runt flag", n_runt - r, 0);
  endtask

  task automatic t_b2b;
    int d = n_drop;
    send(PRIM, 8, 0, 1);
    send(48'h0255_0000_0000, 7, 0, 0);
    send(PRIM, 12, 0, 1);
    send(PRIM, 9, 2, 1);
    settle("R11 back-to-back and gaps", d, 1);
  endtask

  task automatic t_stray;
    int d = n_drop;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1; in_sof = 0; in_eof = (i == 4); in_data = 8'hC0;
    end
    settle("R10 stray bytes", d, 0);
  endtask

  task automatic t_saturate;
    int d = n_drop;
    for (int i = 0; i < 4; i++) send(48'h0299_0000_0000, 7, 0, 0);
    settle("R9 saturation", d, 4);
    check(drop_count == 3'd7, "R9 saturated value", drop_count, 7);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_promisc();
    t_primary();
    t_supp();
    t_mcast();
    t_reserved();
    t_runt();
    t_b2b();
    t_stray();
    t_saturate();
    summary();
  end
endmodule